// File: doc/BRIEF.md
# Bidirectional Serial-In Latched Grid Driver

This block is a chain of shift stages loaded one bit at a time from a serial port. Each stage feeds a level-sensitive latch, and the latches drive a parallel output bus with a blanking override. Its intended load is the grid lines of a display. Each falling clock edge takes in one bit and moves the stored bits along by one stage. The latch control copies the stage contents to the outputs while it is high. The blanking input turns every output off.

There are two serial ports, A and B, and the direction input decides which one receives data and which one transmits. Each port has three signals: data in, data out and an output enable. A board can therefore tie two bidirectional pins to these ports. To build a longer display, the transmitting port of one device is wired to the receiving port of the next. Stage numbering runs from 1 to STAGES. Stage n appears on bit n-1 of the output bus.

Top module: `grid_shift_driver`

## Requirements
- R1: While `rst_n` is low, all stages and latches are asynchronously cleared, so `grid_out` reads all zeros.
- R2: With `dir_fwd` high, each falling clock edge loads `pa_in` into stage 1 (bit 0) and moves stage n into stage n+1.
- R3: With `dir_fwd` low, each falling clock edge loads `pb_in` into stage STAGES (top bit) and moves stage n into stage n-1.
- R4: Exactly one port enable is high at any time. `pb_oe` is high when `dir_fwd` is high, and `pa_oe` is high when `dir_fwd` is low.
- R5: While `latch_en` is high and `blank` is low, `grid_out` follows the stage contents.
- R6: While `latch_en` is low, the latches hold their values. `grid_out` does not change while `blank` stays low, even as shifting continues.
- R7: While `blank` is high, `grid_out` is all zeros whatever the latches hold, and the latch contents are kept.
- R8: `pb_out` carries stage STAGES and `pa_out` carries stage 1. Both change only on a falling clock edge. Two devices chained port B to port A behave as one register of twice the length in either direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, active on the falling edge |
| rst_n | input | 1 | Asynchronous active-low clear |
| dir_fwd | input | 1 | 1: A receives and B transmits; 0: the reverse |
| pa_in | input | 1 | Port A received data |
| pa_out | output | 1 | Port A transmitted data (stage 1) |
| pa_oe | output | 1 | Port A driver enable |
| pb_in | input | 1 | Port B received data |
| pb_out | output | 1 | Port B transmitted data (stage STAGES) |
| pb_oe | output | 1 | Port B driver enable |
| latch_en | input | 1 | Latch transparent when high, hold when low |
| blank | input | 1 | Forces all outputs low when high |
| grid_out | output | STAGES | Parallel outputs, bit n-1 is stage n |

## Verification
The assertions run on every cycle. They check the one-stage move and the serial bit entering at each falling edge in both directions, that exactly one port enable is high, that the outputs follow the stages while the latch is open, that the outputs are frozen while it is closed, and that blanking clears the outputs. Some behaviour only the bench scenarios can show. These are a pattern pushed all the way through the register and surfacing at the far port, a direction change in the middle of a stream, latch contents surviving a blanking period, and two devices in cascade matching a register model of twice the length.

// File: rtl/grid_shift_driver.sv
module grid_shift_driver #(
  parameter int STAGES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_fwd,
  input  logic              pa_in,
  output logic              pa_out,
  output logic              pa_oe,
  input  logic              pb_in,
  output logic              pb_out,
  output logic              pb_oe,
  input  logic              latch_en,
  input  logic              blank,
  output logic [STAGES-1:0] grid_out
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sr;
  logic [STAGES-1:0] lat;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)
      sr <= '0;
    else if (dir_fwd)
      sr <= {sr[TOP-1:0], pa_in};
    else
      sr <= {pb_in, sr[TOP:1]};
  end

  always_latch begin
    if (!rst_n)
      lat <= '0;
    else if (latch_en)
      lat <= sr;
  end

  assign pb_out   = sr[TOP];
  assign pa_out   = sr[0];
  assign pb_oe    = dir_fwd;
  assign pa_oe    = ~dir_fwd;
  assign grid_out = blank ? '0 : lat;
endmodule

// File: rtl/grid_shift_driver_chk.sv
module grid_shift_driver_chk #(
  parameter int STAGES = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dir_fwd,
  input logic              pa_in,
  input logic              pa_out,
  input logic              pa_oe,
  input logic              pb_in,
  input logic              pb_out,
  input logic              pb_oe,
  input logic              latch_en,
  input logic              blank,
  input logic [STAGES-1:0] grid_out,
  input logic [STAGES-1:0] sr
);
  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |-> grid_out == '0);

  a_r2_fwd_shift: assert property (@(negedge clk) disable iff (!rst_n)
    dir_fwd |=> (sr[0] == $past(pa_in)) && (pb_out == $past(sr[STAGES-2])));

  a_r3_rev_shift: assert property (@(negedge clk) disable iff (!rst_n)
    !dir_fwd |=> (sr[STAGES-1] == $past(pb_in)) && (pa_out == $past(sr[1])));

  a_r4_one_driver: assert property (@(posedge clk)
    $countones({pa_oe, pb_oe}) == 1 && pb_oe == dir_fwd);

  a_r5_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && !blank) |-> grid_out == sr);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_en && $past(!latch_en) && !blank && $past(!blank)) |-> $stable(grid_out));

  a_r7_blank: assert property (@(posedge clk) blank |-> grid_out == '0);
endmodule

bind grid_shift_driver grid_shift_driver_chk #(.STAGES(STAGES)) chk_i (.*);

// File: tb/grid_shift_driver_tb_top.sv
module grid_shift_driver_tb_top;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir = 1'b1, a_in = 1'b0, b_in = 1'b0, le = 1'b0, bl = 1'b0;
  logic pa_out_0, pa_oe_0, pb_out_0, pb_oe_0;
  logic pa_out_1, pa_oe_1, pb_out_1, pb_oe_1;
  logic [N-1:0] grid_0, grid_1;

  int checks = 0;
  int fails = 0;
  logic [2*N-1:0] chain = '0;
  logic [N-1:0] lat_0 = '0, lat_1 = '0;

  always #5 clk = ~clk;

  grid_shift_driver #(.STAGES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .dir_fwd(dir),
    .pa_in(a_in), .pa_out(pa_out_0), .pa_oe(pa_oe_0),
    .pb_in(pa_out_1), .pb_out(pb_out_0), .pb_oe(pb_oe_0),
    .latch_en(le), .blank(bl), .grid_out(grid_0));

  grid_shift_driver #(.STAGES(N)) dut_b (
    .clk(clk), .rst_n(rst_n), .dir_fwd(dir),
    .pa_in(pb_out_0), .pa_out(pa_out_1), .pa_oe(pa_oe_1),
    .pb_in(b_in), .pb_out(pb_out_1), .pb_oe(pb_oe_1),
    .latch_en(le), .blank(bl), .grid_out(grid_1));

  function automatic logic [N-1:0] vis(input logic [N-1:0] l, input logic b);
    return b ? '0 : l;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic a, input logic b, input logic d, input logic l, input logic k);
    string gt;
    a_in = a; b_in = b; dir = d; le = l; bl = k;
    @(negedge clk);
    if (d) chain = {chain[2*N-2:0], a};
    else   chain = {b, chain[2*N-1:1]};
    @(posedge clk); #1;
    if (l) begin lat_0 = chain[N-1:0]; lat_1 = chain[2*N-1:N]; end
    gt = k ? "R7 grid" : (l ? "R5 grid" : "R6 grid");
    chk(gt, 64'(grid_0), 64'(vis(lat_0, k)));
    chk({"R8 ", gt}, 64'(grid_1), 64'(vis(lat_1, k)));
    if (d) chk("R2 stage end", 64'(pb_out_0), 64'(chain[N-1]));
    else   chk("R3 stage end", 64'(pa_out_0), 64'(chain[0]));
    chk("R8 chain out", 64'(d ? pb_out_1 : pa_out_0), 64'(d ? chain[2*N-1] : chain[0]));
    chk("R4 enables", 64'({pa_oe_0, pb_oe_0, pa_oe_1, pb_oe_1}), 64'({~d, d, ~d, d}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset grid", 64'({grid_1, grid_0}), 64'd0);
    chk("R1 reset serial", 64'({pa_out_0, pb_out_0}), 64'd0);
    chk("R4 reset enables", 64'({pa_oe_0, pb_oe_0}), 64'b01);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R6: fill forward with latch closed, outputs stay at zero
    for (int i = 0; i < N; i++) step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    // R5: open latch
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    // R7: blank while latch holds, then unblank and see contents return
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    // R3: reverse stream of alternating bits through both devices
    for (int i = 0; i < 2*N + 3; i++) step(1'b0, 1'(i & 1), 1'b0, 1'b1, 1'b0);
    // R2: forward single one walking across the cascade
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 2*N; i++) step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    // random mix
    for (int i = 0; i < 600; i++)
      step(1'($urandom), 1'($urandom), ($urandom % 8) != 0,
           ($urandom % 3) != 0, ($urandom % 6) == 0);
    // R1: asynchronous reset mid-stream
    #2 rst_n = 1'b0;
    #1;
    chk("R1 async clear", 64'({grid_1, grid_0}), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule